// File: doc/BRIEF.md
# Address-Decoded Flash Command Engine

This block sits between a simple request/acknowledge host port and a 16-bit asynchronous NOR flash device. The host carries out a whole flash operation with a single access. The two top address bits of the 28-bit byte address pick the kind of operation:

- a plain array read or program;
- a block unlock;
- a block erase;
- a small control window holding a busy/command register, the latched device status byte, and read windows onto the device identifier and query tables.

The engine expands each access into the multi-cycle command sequence the flash needs. It polls the device until a program or erase finishes, latches the final status byte, and always leaves the device back in array-read mode. Strobe widths are set in core clock cycles by two parameters.

A program, unlock, erase or control write is acknowledged as soon as it is launched. Software can then watch the busy bit while the flash works. Reads are acknowledged once their data has been captured. Control and status reads are answered at once even while an operation runs. Any other access that arrives while the engine is busy is held off until the engine is idle.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, busy and ack are 0; chip enable, write, output-enable and device-reset strobes are all inactive (high); and the data bus is not driven.
- R2: A read with addr[27:26]=00 and wide=0 performs one flash read at word address addr[24:1]. Output enable is low for exactly RD_CYC clocks. The access is acknowledged with rdata = {16'h0, flash data}.
- R3: A read with addr[27:26]=00 and wide=1 performs two reads, at word address A=addr[24:1] and then at A+1. It returns rdata = {data at A+1, data at A}.
- R4: A write with addr[27:26]=00 is acknowledged one cycle after the request, with busy high. The flash receives 0x0040 then the low halfword at A, then 0x0070 at A. Status is polled until bit 7 is set. With wide=1 the same three writes follow at A+1 using the high halfword. The sequence ends with 0x00FF.
- R5: Every flash write cycle holds write enable and chip enable low for exactly WR_CYC clocks, with output enable high and the bus driven. Address and data stay stable while a strobe is low. Strobes return high for at least one clock between bus cycles.
- R6: Any access with addr[27:26]=01 writes 0x0060 and then 0x00D0 to word address addr[24:1], followed by 0x00FF, with no status polling.
- R7: Any access with addr[27:26]=10 writes 0x0020 and then 0x00D0 to word address addr[24:1]. It then writes 0x0070, polls until status bit 7 is set, and finishes with 0x00FF.
- R8: A read of byte address 0xC000000 returns the busy flag in bit 0. A read of 0xC000004 returns in bits [7:0] the status byte latched at the last completed poll. Both are acknowledged one cycle after the request, even while busy.
- R9: An array, unlock, erase or window access issued while busy is not acknowledged and starts no flash cycle until the running operation has finished.
- R10: A write to 0xC000000 with wdata bit 1 set writes 0x0050 then 0x00FF to the flash and clears the latched status byte to 0.
- R11: A write to 0xC000000 with wdata bit 2 set is accepted even while busy. It aborts any operation and drives the device reset low for exactly RST_CYC clocks. It then writes 0x00FF, clears the latched status byte, and returns to idle within RST_CYC+WR_CYC+4 clocks.
- R12: An access with addr[27:25]=111 and addr[16]=0 writes 0x0090 to word address {addr[24:17],0,addr[15:1]}. It then reads that address, writes 0x00FF, and returns the data in rdata[15:0].
- R13: An access with addr[27:25]=111 and addr[16]=1 writes 0x0098 to word address addr[15:1]. It then reads that address, writes 0x00FF, and returns the data in rdata[15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; also the unit for strobe timing |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until ack |
| we | input | 1 | 1 for write access, 0 for read |
| wide | input | 1 | 1 for a 32-bit array access, 0 for 16-bit |
| addr | input | 28 | Byte address; bits [27:26] select the operation |
| wdata | input | 32 | Write data or control bits |
| ack | output | 1 | One-cycle acknowledge |
| rdata | output | 32 | Read data, valid with ack |
| busy | output | 1 | High while a flash sequence runs |
| fl_addr | output | 24 | Flash word address |
| fl_dq_o | output | 16 | Data toward the flash |
| fl_dq_oe | output | 1 | Enable for fl_dq_o onto the flash bus |
| fl_dq_i | input | 16 | Data from the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_rst_n | output | 1 | Flash device reset, active low |

## Verification
The flash model in the bench holds status-not-ready for a random number of polls. A sequencer that skipped the poll loop, or took the wrong branch out of it, would then write 0x00FF too early or lose the high half of a 32-bit program.

A control read issued during a never-finishing erase must come back in one cycle with busy set. A reset issued in the middle of that erase must cut the strobe cleanly, give a device reset of exact width and end idle. A design that queued register reads behind the sequencer would hang here, and one that ignored the abort would poll forever.

An array read issued right after a program launch must not touch the bus until the program's 0x00FF has gone out. The order of halves in 32-bit reads and the address folding in the identifier window are checked against independently computed patterns.

// File: rtl/flash_cmd_engine.sv
`timescale 1ns/1ps
module flash_cmd_engine #(
  parameter int WR_CYC  = 4,
  parameter int RD_CYC  = 6,
  parameter int RST_CYC = 8
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic        wide,
  input  logic [27:0] addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata,
  output logic        busy,
  output logic [23:0] fl_addr,
  output logic [15:0] fl_dq_o,
  output logic        fl_dq_oe,
  input  logic [15:0] fl_dq_i,
  output logic        fl_ce_n,
  output logic        fl_we_n,
  output logic        fl_oe_n,
  output logic        fl_rst_n
);
  localparam int MX1 = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int MX  = (MX1 > RST_CYC) ? MX1 : RST_CYC;
  localparam int TW  = $clog2(MX + 2);
  localparam logic [TW-1:0] WL = TW'(WR_CYC);
  localparam logic [TW-1:0] RL = TW'(RD_CYC);
  localparam logic [TW-1:0] XL = TW'(RST_CYC);

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_CMD1, S_CMD2, S_STAT, S_POLL, S_READ, S_READ2, S_ARRAY
  } st_t;
  typedef enum logic [2:0] {
    OP_RD, OP_PROG, OP_UNLK, OP_ERASE, OP_ID, OP_QRY, OP_CLR
  } op_t;

  st_t          st;
  op_t          op;
  logic [TW-1:0] tmr;
  logic [23:0]  a;
  logic [31:0]  dat;
  logic         wide_q;
  logic [15:0]  cap;
  logic [7:0]   stat;

  logic reg_sp, ctl_sp, win_sp, ctl_rd, rst_cmd, launch;
  logic is_rd, is_wr, strobe, cyc_end;
  logic [TW-1:0] lim;
  logic unused_bits;

  assign unused_bits = addr[0];

  assign reg_sp  = addr[27:26] == 2'b11;
  assign ctl_sp  = reg_sp & ~addr[25];
  assign win_sp  = reg_sp & addr[25];
  assign ctl_rd  = req & ~ack & ctl_sp & ~we;
  assign rst_cmd = req & ~ack & ctl_sp & we & wdata[2];
  assign launch  = req & ~ack & (st == S_IDLE) & ~ctl_rd & ~rst_cmd;

  assign is_rd = (st == S_READ) | (st == S_READ2) | (st == S_POLL);
  assign is_wr = (st == S_CMD1) | (st == S_CMD2) | (st == S_STAT) | (st == S_ARRAY);

  always_comb begin
    if (st == S_RST)  lim = XL;
    else if (is_rd)   lim = RL;
    else              lim = WL;
  end

  assign strobe  = (is_rd | is_wr) & (tmr < lim);
  assign cyc_end = (st != S_IDLE) & (tmr == lim);

  assign busy     = st != S_IDLE;
  assign fl_addr  = a;
  assign fl_ce_n  = ~strobe;
  assign fl_we_n  = ~(strobe & is_wr);
  assign fl_oe_n  = ~(strobe & is_rd);
  assign fl_dq_oe = is_wr;
  assign fl_rst_n = ~((st == S_RST) & (tmr < XL));

  always_comb begin
    fl_dq_o = 16'h0000;
    case (st)
      S_CMD1:
        case (op)
          OP_PROG:  fl_dq_o = 16'h0040;
          OP_UNLK:  fl_dq_o = 16'h0060;
          OP_ERASE: fl_dq_o = 16'h0020;
          OP_ID:    fl_dq_o = 16'h0090;
          OP_QRY:   fl_dq_o = 16'h0098;
          OP_CLR:   fl_dq_o = 16'h0050;
          default:  fl_dq_o = 16'h00FF;
        endcase
      S_CMD2:  fl_dq_o = (op == OP_PROG) ? dat[15:0] : 16'h00D0;
      S_STAT:  fl_dq_o = 16'h0070;
      S_ARRAY: fl_dq_o = 16'h00FF;
      default: fl_dq_o = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op     <= OP_RD;
      tmr    <= '0;
      a      <= '0;
      dat    <= '0;
      wide_q <= 1'b0;
      cap    <= '0;
      stat   <= '0;
      ack    <= 1'b0;
      rdata  <= '0;
    end else begin
      ack <= 1'b0;
      if (is_rd && tmr == RL - 1'b1) cap <= fl_dq_i;

      if (ctl_rd) begin
        ack   <= 1'b1;
        rdata <= addr[2] ? {24'h0, stat} : {31'h0, busy};
      end

      if (rst_cmd) begin
        ack    <= 1'b1;
        st     <= S_RST;
        op     <= OP_RD;
        tmr    <= '0;
        stat   <= '0;
        wide_q <= 1'b0;
      end else if (launch) begin
        tmr <= '0;
        dat <= wdata;
        if (ctl_sp) begin
          ack <= 1'b1;
          if (wdata[1]) begin
            op <= OP_CLR;
            st <= S_CMD1;
          end
        end else if (win_sp) begin
          op <= addr[16] ? OP_QRY : OP_ID;
          a  <= addr[16] ? {9'h0, addr[15:1]} : {addr[24:17], 1'b0, addr[15:1]};
          st <= S_CMD1;
        end else begin
          a      <= addr[24:1];
          wide_q <= wide;
          case (addr[27:26])
            2'b01:   begin op <= OP_UNLK;  st <= S_CMD1; ack <= 1'b1; end
            2'b10:   begin op <= OP_ERASE; st <= S_CMD1; ack <= 1'b1; end
            default: begin
              if (we) begin op <= OP_PROG; st <= S_CMD1; ack <= 1'b1; end
              else    begin op <= OP_RD;   st <= S_READ; end
            end
          endcase
        end
      end else if (cyc_end) begin
        tmr <= '0;
        case (st)
          S_RST:  st <= S_ARRAY;
          S_CMD1:
            case (op)
              OP_PROG, OP_UNLK, OP_ERASE: st <= S_CMD2;
              OP_ID, OP_QRY:              st <= S_READ;
              OP_CLR: begin st <= S_ARRAY; stat <= '0; end
              default:                    st <= S_ARRAY;
            endcase
          S_CMD2: st <= (op == OP_UNLK) ? S_ARRAY : S_STAT;
          S_STAT: st <= S_POLL;
          S_POLL: begin
            if (cap[7]) begin
              stat <= cap[7:0];
              if (op == OP_PROG && wide_q) begin
                wide_q <= 1'b0;
                a      <= a + 24'd1;
                dat    <= {16'h0, dat[31:16]};
                st     <= S_CMD1;
              end else begin
                st <= S_ARRAY;
              end
            end
          end
          S_READ: begin
            rdata <= {16'h0, cap};
            if (op == OP_RD) begin
              if (wide_q) begin
                a  <= a + 24'd1;
                st <= S_READ2;
              end else begin
                ack <= 1'b1;
                st  <= S_IDLE;
              end
            end else begin
              st <= S_ARRAY;
            end
          end
          S_READ2: begin
            rdata <= {cap, rdata[15:0]};
            ack   <= 1'b1;
            st    <= S_IDLE;
          end
          S_ARRAY: begin
            if (op == OP_ID || op == OP_QRY) ack <= 1'b1;
            st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end else if (st != S_IDLE) begin
        tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_engine_chk.sv
`timescale 1ns/1ps
module flash_cmd_engine_chk #(
  parameter int WR_CYC = 4,
  parameter int RD_CYC = 6
)(
  input logic        clk,
  input logic        rst_n,
  input logic        ack,
  input logic        busy,
  input logic        fl_ce_n,
  input logic        fl_we_n,
  input logic        fl_oe_n,
  input logic        fl_rst_n,
  input logic        fl_dq_oe,
  input logic [23:0] fl_addr,
  input logic [15:0] fl_dq_o
);
  logic [15:0] we_cnt, oe_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_cnt <= '0;
      oe_cnt <= '0;
    end else begin
      we_cnt <= fl_we_n ? 16'd0 : we_cnt + 16'd1;
      oe_cnt <= fl_oe_n ? 16'd0 : oe_cnt + 16'd1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n)); // R5
  AST_CE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n); // R5
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> fl_dq_oe); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr)); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> $stable(fl_dq_o)); // R5
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_we_n) && fl_rst_n) |-> (we_cnt == 16'(WR_CYC))); // R5
  AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_oe_n) && fl_rst_n) |-> (oe_cnt == 16'(RD_CYC))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl_ce_n && fl_rst_n)); // R9
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_rst_n |-> (fl_ce_n && busy)); // R11
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R8
endmodule

bind flash_cmd_engine flash_cmd_engine_chk #(.WR_CYC(WR_CYC), .RD_CYC(RD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .busy(busy), .fl_ce_n(fl_ce_n),
  .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_rst_n(fl_rst_n),
  .fl_dq_oe(fl_dq_oe), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o)
);

// File: tb/flash_cmd_engine_tb.sv
`timescale 1ns/1ps
module flash_cmd_engine_tb;
  localparam int WRC = 3, RDC = 5, RSC = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req = 0, we = 0, wide = 0;
  logic [27:0] addr = '0;
  logic [31:0] wdata = '0;
  logic ack, busy, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n;
  logic [31:0] rdata;
  logic [23:0] fl_addr;
  logic [15:0] fl_dq_o;
  logic [15:0] fl_dq_i = '0;

  flash_cmd_engine #(.WR_CYC(WRC), .RD_CYC(RDC), .RST_CYC(RSC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .wide(wide), .addr(addr),
    .wdata(wdata), .ack(ack), .rdata(rdata), .busy(busy), .fl_addr(fl_addr),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_rst_n(fl_rst_n)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] arr_pat(input logic [23:0] x);
    return x[15:0] ^ {x[23:16], x[23:16]} ^ 16'h3C5A;
  endfunction
  function automatic logic [15:0] id_pat(input logic [23:0] x);
    return 16'h8900 ^ x[15:0];
  endfunction
  function automatic logic [15:0] qry_pat(input logic [23:0] x);
    return 16'h5100 ^ x[15:0];
  endfunction

  // flash model
  localparam int M_ARR = 0, M_STS = 1, M_ID = 2, M_QRY = 3;
  logic [15:0] fmem [logic [23:0]];
  int mode = M_ARR, poll_left = 0, welo = 0, oelo = 0, rstlo = 0, last_rst_w = 0;
  bit pend_prog = 0, pend_lock = 0, pend_ers = 0, hold = 0;
  logic [6:0] sx = '0;
  logic [23:0] la;
  logic [15:0] ld;
  logic [39:0] wlog[$];
  logic [39:0] exq[$];

  function automatic logic [15:0] rd_val(input logic [23:0] x);
    case (mode)
      M_STS:   return (hold || poll_left > 0) ? 16'h0000 : {8'h00, 1'b1, sx};
      M_ID:    return id_pat(x);
      M_QRY:   return qry_pat(x);
      default: return fmem.exists(x) ? fmem[x] : arr_pat(x);
    endcase
  endfunction

  task commit(input logic [23:0] x, input logic [15:0] d);
    wlog.push_back({x, d});
    if (pend_prog) begin
      fmem[x] = d; pend_prog = 0; mode = M_STS;
      poll_left = $urandom % 4; sx = 7'($urandom);
    end else begin
      case (d[7:0])
        8'hFF: mode = M_ARR;
        8'h70: mode = M_STS;
        8'h50: sx = '0;
        8'h90: mode = M_ID;
        8'h98: mode = M_QRY;
        8'h40: pend_prog = 1;
        8'h60: pend_lock = 1;
        8'h20: pend_ers = 1;
        8'hD0: begin
          mode = M_STS;
          if (pend_ers) begin poll_left = $urandom % 4; sx = 7'($urandom); end
          else poll_left = 0;
          pend_ers = 0; pend_lock = 0;
        end
        default: ;
      endcase
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_rst_n) begin
        rstlo++; mode = M_ARR; pend_prog = 0; pend_lock = 0; pend_ers = 0;
        welo = 0; oelo = 0;
      end else begin
        if (rstlo != 0) begin last_rst_w = rstlo; rstlo = 0; end
        if (!fl_we_n) begin welo++; la = fl_addr; ld = fl_dq_o; end
        else if (welo != 0) begin
          chk(welo == WRC, "R5 write strobe width", welo, WRC);
          commit(la, ld); welo = 0;
        end
        if (!fl_oe_n) oelo++;
        else if (oelo != 0) begin
          chk(oelo == RDC, "R2 read strobe width", oelo, RDC);
          if (mode == M_STS && poll_left > 0) poll_left--;
          oelo = 0;
        end
      end
    end
    fl_dq_i = fl_oe_n ? 16'h0000 : rd_val(fl_addr);
  end

  // host side
  logic [15:0] refm [logic [23:0]];
  function automatic logic [15:0] ref_rd(input logic [23:0] x);
    return refm.exists(x) ? refm[x] : arr_pat(x);
  endfunction

  task automatic acc(input bit w, input logic [27:0] ad, input logic [31:0] wd,
                     input bit wi, output logic [31:0] rd, output int lat);
    @(negedge clk);
    req = 1; we = w; addr = ad; wdata = wd; wide = wi; lat = 0;
    do begin @(negedge clk); lat++; end while (!ack && lat < 20000);
    rd = rdata; req = 0; we = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic ex(input logic [23:0] x, input logic [15:0] d);
    exq.push_back({x, d});
  endtask

  task automatic chk_log(input string tag);
    chk(wlog.size() == exq.size(), {tag, " write count"}, wlog.size(), exq.size());
    for (int i = 0; i < exq.size() && i < wlog.size(); i++)
      chk(wlog[i] == exq[i], {tag, " write sequence"}, wlog[i][31:0], exq[i][31:0]);
    wlog.delete(); exq.delete();
  endtask

  logic [23:0] last_a;

  task automatic check_status(input string tag, input logic [7:0] e);
    logic [31:0] r; int l;
    acc(0, 28'hC000004, 0, 0, r, l);
    chk(r == {24'h0, e}, tag, r, {24'h0, e});
  endtask

  task automatic prog_go(input logic [23:0] wa, input logic [31:0] d, input bit wi);
    logic [31:0] r; int l;
    acc(1, {3'b000, wa, 1'b0}, d, wi, r, l);
    chk(l == 1, "R4 program ack at launch", l, 1);
    chk(busy == 1'b1, "R4 busy after launch", busy, 1);
    ex(wa, 16'h0040); ex(wa, d[15:0]); ex(wa, 16'h0070);
    refm[wa] = d[15:0]; last_a = wa;
    if (wi) begin
      ex(wa + 1, 16'h0040); ex(wa + 1, d[31:16]); ex(wa + 1, 16'h0070);
      refm[wa + 1] = d[31:16]; last_a = wa + 1;
    end
    ex(last_a, 16'h00FF);
  endtask

  task automatic do_prog(input logic [23:0] wa, input logic [31:0] d, input bit wi);
    prog_go(wa, d, wi);
    wait_idle();
    chk_log("R4");
    check_status("R8 status after program", {1'b1, sx});
  endtask

  task automatic do_read(input logic [23:0] wa, input bit wi);
    logic [31:0] r, e; int l;
    acc(0, {3'b000, wa, 1'b0}, 0, wi, r, l);
    if (wi) begin
      e = {ref_rd(wa + 1), ref_rd(wa)};
      chk(r == e, "R3 wide read data", r, e);
    end else begin
      e = {16'h0, ref_rd(wa)};
      chk(r == e, "R2 read data", r, e);
    end
    chk_log("R2 no writes on read");
  endtask

  task automatic do_unlock(input logic [23:0] wa);
    logic [31:0] r; int l;
    acc(1, {3'b010, wa, 1'b0}, 0, 0, r, l);
    wait_idle();
    ex(wa, 16'h0060); ex(wa, 16'h00D0); ex(wa, 16'h00FF);
    chk_log("R6"); last_a = wa;
  endtask

  task automatic do_erase(input logic [23:0] wa);
    logic [31:0] r; int l;
    acc(1, {3'b100, wa, 1'b0}, 0, 0, r, l);
    chk(l == 1, "R7 erase ack at launch", l, 1);
    wait_idle();
    ex(wa, 16'h0020); ex(wa, 16'h00D0); ex(wa, 16'h0070); ex(wa, 16'h00FF);
    chk_log("R7"); last_a = wa;
    check_status("R7 latched status", {1'b1, sx});
  endtask

  task automatic do_id(input logic [7:0] blk, input logic [14:0] off);
    logic [31:0] r; int l; logic [23:0] fa;
    fa = {blk, 1'b0, off};
    acc(0, {3'b111, blk, 1'b0, off, 1'b0}, 0, 0, r, l);
    chk(r == {16'h0, id_pat(fa)}, "R12 identifier data", r, {16'h0, id_pat(fa)});
    ex(fa, 16'h0090); ex(fa, 16'h00FF);
    chk_log("R12"); last_a = fa;
  endtask

  task automatic do_qry(input logic [14:0] off);
    logic [31:0] r; int l; logic [23:0] fa;
    fa = {9'h0, off};
    acc(0, {3'b111, 8'h00, 1'b1, off, 1'b0}, 0, 0, r, l);
    chk(r == {16'h0, qry_pat(fa)}, "R13 query data", r, {16'h0, qry_pat(fa)});
    ex(fa, 16'h0098); ex(fa, 16'h00FF);
    chk_log("R13"); last_a = fa;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] r; int l, l2;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && ack == 0, "R1 busy/ack in reset", {busy, ack}, 0);
    chk({fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n} == 4'hF, "R1 strobes idle", {fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n}, 4'hF);
    chk(fl_dq_oe == 0, "R1 bus not driven", fl_dq_oe, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && fl_ce_n == 1, "R1 idle after reset", {busy, fl_ce_n}, 1);
    acc(0, 28'hC000000, 0, 0, r, l);
    chk(r == 0, "R8 control read idle", r, 0);
    chk(l == 1, "R8 control read latency", l, 1);

    // directed
    do_read(24'h000010, 0);
    do_read(24'h000020, 1);
    do_prog(24'h000040, 32'hBEEF_1234, 0);
    do_prog(24'h000050, 32'hCAFE_5678, 1);
    do_read(24'h000050, 1);
    do_read(24'h000040, 0);
    do_unlock(24'h020000);
    do_erase(24'h040000);
    do_id(8'h02, 15'h0002);
    do_qry(15'h0010);

    // R9: access while busy waits
    prog_go(24'h000080, 32'h0000_A5A5, 0);
    acc(0, {3'b000, 24'h000080, 1'b0}, 0, 0, r, l);
    chk(wlog.size() == 4, "R9 read held until program done", wlog.size(), 4);
    chk(r == {16'h0, 16'hA5A5}, "R9 read after program", r, {16'h0, 16'hA5A5});
    chk_log("R9");

    // R10 clear status
    acc(1, 28'hC000000, 32'h2, 0, r, l);
    chk(l == 1, "R10 clear ack", l, 1);
    wait_idle();
    ex(last_a, 16'h0050); ex(last_a, 16'h00FF);
    chk_log("R10");
    check_status("R10 status cleared", 8'h00);

    // R8/R11: reads while busy, abort by reset
    do_prog(24'h0000A0, 32'h1111, 0);
    hold = 1;
    acc(1, {3'b100, 24'h060000, 1'b0}, 0, 0, r, l);
    repeat (30) @(negedge clk);
    acc(0, 28'hC000000, 0, 0, r, l);
    chk(l == 1 && r == 1, "R8 busy read during erase", {r[15:0], 16'(l)}, {16'h1, 16'h1});
    acc(0, 28'hC000004, 0, 0, r, l);
    chk(l == 1, "R8 status read latency while busy", l, 1);
    acc(1, 28'hC000000, 32'h4, 0, r, l);
    chk(l == 1, "R11 reset accepted while busy", l, 1);
    l2 = 0;
    while (busy && l2 < 1000) begin @(negedge clk); l2++; end
    chk(l2 <= RSC + WRC + 4, "R11 bounded return to idle", l2, RSC + WRC + 4);
    chk(last_rst_w == RSC, "R11 device reset width", last_rst_w, RSC);
    hold = 0;
    ex(24'h060000, 16'h0020); ex(24'h060000, 16'h00D0); ex(24'h060000, 16'h0070);
    ex(24'h060000, 16'h00FF);
    chk_log("R11");
    check_status("R11 status cleared", 8'h00);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int k;
      logic [23:0] wa;
      k = $urandom % 7;
      wa = 24'(($urandom % 256) * 2);
      case (k)
        0: do_read(wa, 0);
        1: do_read(wa, 1);
        2: do_prog(wa, $urandom, 0);
        3: do_prog(wa, $urandom, 1);
        4: do_unlock({wa[7:0], 16'h0});
        5: do_erase({wa[7:0], 16'h0});
        default: if ($urandom % 2) do_id(8'($urandom), 15'($urandom)); else do_qry(15'($urandom));
      endcase
    end
    done = 1;
    finish_run();
  end
endmodule